// File: doc/BRIEF.md
# Lockable Round-Robin Way Allocator

This block holds the replacement and lock-down state of a 32-set, 32-way instruction cache. For every set it keeps a valid bit per way, a count of locked ways and a round-robin victim pointer. When the fetch side misses, it issues an allocate request carrying the line's virtual address. The block takes the set from the address, returns the victim way one cycle later, marks that way valid and moves the pointer on. A lock request fills the lowest free lockable way of the set and pins it there. Pinned ways are never chosen as round-robin victims.

Commands arrive one per clock on a single port, each with a 3-bit opcode:

| Opcode | Command |
|---|---|
| 0 | allocate |
| 1 | lock-allocate |
| 2 | invalidate all |
| 3 | invalidate one line |
| 4 | unlock all |
| 5 | write control |

The write-control command copies bit 12 of its data word into the enable flag. Allocate and lock requests are dropped while that flag is clear. A status port returns the valid and locked vectors of any chosen set. Tag and data storage live outside this block.

Top module: `lockable_rr_alloc`

## Requirements
- R1: After reset the enable flag `cache_en` is 0, every set has no locked ways and no valid lines, and every pointer is at way 0. The first allocate into a set after enabling therefore returns way 0.
- R2: The set index is taken from `cmd_addr[9:5]`. Bits 4:0 are the line offset. Bits above 9 do not affect which set is chosen. Each set has its own pointer.
- R3: An allocate (opcode 0) returns the current pointer value of the set as the victim way, with `rsp_valid`=1 and `rsp_lock_ok`=0. It marks that way valid and advances the pointer by one.
- R4: When the victim is way 31, the pointer wraps to the lowest unlocked way of the set, which equals the set's lock count.
- R5: A lock-allocate (opcode 1) in a set with fewer than 28 locked ways returns way number equal to the lock count, with `rsp_lock_ok`=1. It marks that way valid and locked, and increments the lock count.
- R6: When an accepted lock raises the lock count above the pointer, the pointer moves to the first unlocked way. The next allocate returns that way.
- R7: A lock-allocate in a set that already has 28 locked ways allocates way 31 as an ordinary line, with `rsp_lock_ok`=0. It leaves the pointer at way 31, so the next allocate also returns way 31.
- R8: Invalidate-all (opcode 2) clears the valid bit of every unlocked way in every set. Locked ways stay valid and locked.
- R9: Invalidate-line (opcode 3) clears only the valid bit of the way given by `cmd_way`, in the set given by `cmd_addr[9:5]`.
- R10: Unlock-all (opcode 4) sets every lock count to 0 and leaves valid bits and pointers unchanged. A later pointer wrap returns to way 0.
- R11: Write-control (opcode 5) loads `cmd_addr[12]` into `cache_en`. While `cache_en` is 0, allocate and lock requests produce no response and change no state.
- R12: Exactly one command is taken per clock. Its response appears in the following cycle. The next command, issued back to back, already sees the updated pointer and lock count.
- R13: `stat_valid` and `stat_locked` show the valid and locked vectors of set `stat_set` one cycle after it is presented. Bit n of each vector stands for way n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Opcode: 0 allocate, 1 lock, 2 invalidate all, 3 invalidate line, 4 unlock all, 5 write control |
| cmd_addr | input | 32 | Virtual address (set in bits 9:5) or control word (enable in bit 12) |
| cmd_way | input | 5 | Way number for invalidate-line |
| stat_set | input | 5 | Set whose status is reported |
| rsp_valid | output | 1 | Registered: allocation response present |
| rsp_way | output | 5 | Registered: chosen way |
| rsp_lock_ok | output | 1 | Registered: lock was accepted |
| cache_en | output | 1 | Registered enable flag |
| stat_valid | output | 32 | Registered valid vector of `stat_set` |
| stat_locked | output | 32 | Registered locked vector of `stat_set` |

## Verification
The assertions check the following invariants in every cycle:
- No set's lock count exceeds 28.
- No pointer rests on a locked way.
- Invalidate-all leaves exactly the locked ways valid.
- Unlock-all clears every lock count without touching valid bits.
- A disabled cache never answers, and an enabled request always answers one cycle later.
- Every accepted lock lands below way 28.

Only the bench's scenarios can show that particular way numbers come out in the right order. These include the wrap to the lowest unlocked way, the jump past freshly locked ways and way 31 being taken twice after a refused lock. The same applies to the status vectors seen after each command.

// File: rtl/lrr_pkg.sv
package lrr_pkg;

  typedef enum logic [2:0] {
    OP_ALLOC    = 3'd0,
    OP_LOCK     = 3'd1,
    OP_INV_ALL  = 3'd2,
    OP_INV_LINE = 3'd3,
    OP_UNLOCK   = 3'd4,
    OP_CTRL     = 3'd5
  } op_e;

  typedef struct packed {
    logic alloc;
    logic lock;
    logic inv_all;
    logic inv_line;
    logic unlock;
    logic ctrl;
  } strobe_t;

endpackage

// File: rtl/lrr_cmd_decode.sv
module lrr_cmd_decode (
  input  logic           cmd_valid,
  input  logic [2:0]     cmd_op,
  input  logic           en,
  output lrr_pkg::strobe_t st
);
  import lrr_pkg::*;

  op_e op;

  always_comb begin
    op          = op_e'(cmd_op);
    st          = '0;
    st.alloc    = cmd_valid && en && (op == OP_ALLOC);
    st.lock     = cmd_valid && en && (op == OP_LOCK);
    st.inv_all  = cmd_valid && (op == OP_INV_ALL);
    st.inv_line = cmd_valid && (op == OP_INV_LINE);
    st.unlock   = cmd_valid && (op == OP_UNLOCK);
    st.ctrl     = cmd_valid && (op == OP_CTRL);
  end

endmodule

// File: rtl/lrr_victim_pick.sv
module lrr_victim_pick #(
  parameter int WAYS     = 32,
  parameter int MAX_LOCK = 28,
  localparam int WAY_W   = $clog2(WAYS),
  localparam int CNT_W   = $clog2(WAYS + 1)
) (
  input  logic             lock_req,
  input  logic [CNT_W-1:0] cnt,
  input  logic [WAY_W-1:0] ptr,
  output logic [WAY_W-1:0] way,
  output logic             lock_ok,
  output logic [CNT_W-1:0] nxt_cnt,
  output logic [WAY_W-1:0] nxt_ptr
);

  localparam logic [WAY_W-1:0] TOP_WAY = WAY_W'(WAYS - 1);

  always_comb begin
    lock_ok = lock_req && (cnt < CNT_W'(MAX_LOCK));
    nxt_cnt = cnt;
    if (lock_ok) begin
      // fill the lowest free lockable way, then push the pointer past it
      way     = cnt[WAY_W-1:0];
      nxt_cnt = cnt + CNT_W'(1);
      nxt_ptr = (CNT_W'(ptr) < nxt_cnt) ? nxt_cnt[WAY_W-1:0] : ptr;
    end else if (lock_req) begin
      // lock region full: ordinary fill of the top way, pointer parked there
      way     = TOP_WAY;
      nxt_ptr = TOP_WAY;
    end else begin
      way     = ptr;
      nxt_ptr = (ptr == TOP_WAY) ? cnt[WAY_W-1:0] : ptr + WAY_W'(1);
    end
  end

endmodule

// File: rtl/lrr_set_store.sv
module lrr_set_store #(
  parameter int SETS     = 32,
  parameter int WAYS     = 32,
  parameter int MAX_LOCK = 28,
  localparam int SET_W   = $clog2(SETS),
  localparam int WAY_W   = $clog2(WAYS),
  localparam int CNT_W   = $clog2(WAYS + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SET_W-1:0] sel_set,
  output logic [CNT_W-1:0] sel_cnt,
  output logic [WAY_W-1:0] sel_ptr,
  input  logic             wr_en,
  input  logic [WAY_W-1:0] wr_way,
  input  logic [CNT_W-1:0] wr_cnt,
  input  logic [WAY_W-1:0] wr_ptr,
  input  logic             inv_all,
  input  logic             inv_line,
  input  logic [WAY_W-1:0] inv_way,
  input  logic             unlock_all,
  input  logic [SET_W-1:0] stat_set,
  output logic [WAYS-1:0]  stat_valid,
  output logic [WAYS-1:0]  stat_locked
);

  logic [WAYS-1:0]  valid_q [SETS];
  logic [CNT_W-1:0] cnt_q   [SETS];
  logic [WAY_W-1:0] ptr_q   [SETS];

  function automatic logic [WAYS-1:0] lmask(input logic [CNT_W-1:0] c);
    logic [WAYS-1:0] m;
    for (int w = 0; w < WAYS; w++) m[w] = (w < int'(c));
    return m;
  endfunction

  always_comb begin
    sel_cnt = cnt_q[sel_set];
    sel_ptr = ptr_q[sel_set];
  end

  for (genvar s = 0; s < SETS; s++) begin : g_set
    logic hit;
    assign hit = (sel_set == SET_W'(s));

    always_ff @(posedge clk) begin
      if (rst) begin
        valid_q[s] <= '0;
        cnt_q[s]   <= '0;
        ptr_q[s]   <= '0;
      end else begin
        if (inv_all)          valid_q[s] <= valid_q[s] & lmask(cnt_q[s]);
        if (inv_line && hit)  valid_q[s][inv_way] <= 1'b0;
        if (unlock_all)       cnt_q[s] <= '0;
        if (wr_en && hit) begin
          valid_q[s][wr_way] <= 1'b1;
          cnt_q[s]           <= wr_cnt;
          ptr_q[s]           <= wr_ptr;
        end
      end
    end

    assert_lock_cap_R5: assert property (@(posedge clk) disable iff (rst)
      cnt_q[s] <= CNT_W'(MAX_LOCK));

    assert_ptr_unlocked_R6: assert property (@(posedge clk) disable iff (rst)
      CNT_W'(ptr_q[s]) >= cnt_q[s]);

    assert_inv_keeps_locked_R8: assert property (@(posedge clk) disable iff (rst)
      inv_all |=> ((valid_q[s] & lmask(cnt_q[s])) == ($past(valid_q[s]) & lmask(cnt_q[s]))));

    assert_inv_clears_unlocked_R8: assert property (@(posedge clk) disable iff (rst)
      inv_all |=> ((valid_q[s] & ~lmask(cnt_q[s])) == '0));

    assert_unlock_keeps_valid_R10: assert property (@(posedge clk) disable iff (rst)
      unlock_all |=> (cnt_q[s] == '0) && (valid_q[s] == $past(valid_q[s])));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_valid  <= '0;
      stat_locked <= '0;
    end else begin
      stat_valid  <= valid_q[stat_set];
      stat_locked <= lmask(cnt_q[stat_set]);
    end
  end

endmodule

// File: rtl/lockable_rr_alloc.sv
module lockable_rr_alloc #(
  parameter int SETS       = 32,
  parameter int WAYS       = 32,
  parameter int MAX_LOCK   = 28,
  parameter int LINE_BYTES = 32,
  parameter int ADDR_W     = 32,
  parameter int EN_BIT     = 12,
  localparam int SET_W     = $clog2(SETS),
  localparam int WAY_W     = $clog2(WAYS),
  localparam int OFF_W     = $clog2(LINE_BYTES),
  localparam int CNT_W     = $clog2(WAYS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [WAY_W-1:0]  cmd_way,
  input  logic [SET_W-1:0]  stat_set,
  output logic              rsp_valid,
  output logic [WAY_W-1:0]  rsp_way,
  output logic              rsp_lock_ok,
  output logic              cache_en,
  output logic [WAYS-1:0]   stat_valid,
  output logic [WAYS-1:0]   stat_locked
);
  import lrr_pkg::*;

  strobe_t          st;
  logic [SET_W-1:0] set_idx;
  logic [CNT_W-1:0] cur_cnt, nxt_cnt;
  logic [WAY_W-1:0] cur_ptr, nxt_ptr, pick_way;
  logic             lock_ok;
  logic             addr_unused;

  assign set_idx     = cmd_addr[OFF_W +: SET_W];
  assign addr_unused = ^cmd_addr;

  lrr_cmd_decode u_dec (
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .en        (cache_en),
    .st        (st)
  );

  lrr_victim_pick #(.WAYS(WAYS), .MAX_LOCK(MAX_LOCK)) u_pick (
    .lock_req (st.lock),
    .cnt      (cur_cnt),
    .ptr      (cur_ptr),
    .way      (pick_way),
    .lock_ok  (lock_ok),
    .nxt_cnt  (nxt_cnt),
    .nxt_ptr  (nxt_ptr)
  );

  lrr_set_store #(.SETS(SETS), .WAYS(WAYS), .MAX_LOCK(MAX_LOCK)) u_store (
    .clk         (clk),
    .rst         (rst),
    .sel_set     (set_idx),
    .sel_cnt     (cur_cnt),
    .sel_ptr     (cur_ptr),
    .wr_en       (st.alloc | st.lock),
    .wr_way      (pick_way),
    .wr_cnt      (nxt_cnt),
    .wr_ptr      (nxt_ptr),
    .inv_all     (st.inv_all),
    .inv_line    (st.inv_line),
    .inv_way     (cmd_way),
    .unlock_all  (st.unlock),
    .stat_set    (stat_set),
    .stat_valid  (stat_valid),
    .stat_locked (stat_locked)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid   <= 1'b0;
      rsp_way     <= '0;
      rsp_lock_ok <= 1'b0;
      cache_en    <= 1'b0;
    end else begin
      rsp_valid   <= st.alloc | st.lock;
      rsp_way     <= pick_way;
      rsp_lock_ok <= st.lock & lock_ok;
      if (st.ctrl) cache_en <= cmd_addr[EN_BIT];
    end
  end

  assert_disabled_ignored_R11: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !cache_en && (cmd_op == OP_ALLOC || cmd_op == OP_LOCK)) |=> !rsp_valid);

  assert_rsp_next_cycle_R12: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cache_en && (cmd_op == OP_ALLOC || cmd_op == OP_LOCK)) |=> rsp_valid);

  assert_lock_below_cap_R5: assert property (@(posedge clk) disable iff (rst)
    rsp_lock_ok |-> (rsp_valid && (CNT_W'(rsp_way) < CNT_W'(MAX_LOCK))));

  assert_alloc_no_lock_flag_R3: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == OP_ALLOC) |=> !rsp_lock_ok);

endmodule

// File: tb/tb_lockable_rr_alloc.sv
`timescale 1ns/1ps
module tb_lockable_rr_alloc;

  logic        clk = 1'b0;
  logic        rst;
  logic        cmd_valid;
  logic [2:0]  cmd_op;
  logic [31:0] cmd_addr;
  logic [4:0]  cmd_way;
  logic [4:0]  stat_set;
  logic        rsp_valid;
  logic [4:0]  rsp_way;
  logic        rsp_lock_ok;
  logic        cache_en;
  logic [31:0] stat_valid;
  logic [31:0] stat_locked;

  int nchk = 0;
  int nerr = 0;

  always #2.5 clk = ~clk;

  lockable_rr_alloc dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_way(cmd_way), .stat_set(stat_set),
    .rsp_valid(rsp_valid), .rsp_way(rsp_way), .rsp_lock_ok(rsp_lock_ok),
    .cache_en(cache_en), .stat_valid(stat_valid), .stat_locked(stat_locked)
  );

  localparam logic [2:0] ALC = 3'd0, LCK = 3'd1, IVA = 3'd2, IVL = 3'd3,
                         UNL = 3'd4, CTL = 3'd5;
  localparam logic [15:0] S3 = 16'h0060, S5 = 16'h00A0, EN = 16'h1000;

  // {op, addr, exp_valid, exp_way, exp_lock}
  localparam int NV = 16;
  localparam logic [25:0] VEC [NV] = '{
    {ALC, S3,       1'b0, 5'd0, 1'b0},  // R11 disabled
    {CTL, EN,       1'b0, 5'd0, 1'b0},  // R11 enable
    {ALC, S3,       1'b1, 5'd0, 1'b0},  // R1 first way 0
    {ALC, S3,       1'b1, 5'd1, 1'b0},  // R3
    {ALC, S5,       1'b1, 5'd0, 1'b0},  // R2 own pointer
    {LCK, S3,       1'b1, 5'd0, 1'b1},  // R5
    {LCK, S3,       1'b1, 5'd1, 1'b1},  // R5
    {LCK, S3,       1'b1, 5'd2, 1'b1},  // R6 pointer pushed to 3
    {ALC, S3,       1'b1, 5'd3, 1'b0},  // R6
    {UNL, 16'h0,    1'b0, 5'd0, 1'b0},  // R10
    {ALC, S3,       1'b1, 5'd4, 1'b0},  // R10 pointer kept
    {CTL, 16'h0,    1'b0, 5'd0, 1'b0},  // R11 disable
    {LCK, S3,       1'b0, 5'd0, 1'b0},  // R11 ignored
    {CTL, EN,       1'b0, 5'd0, 1'b0},  // R11
    {ALC, S3,       1'b1, 5'd5, 1'b0},  // R11 state untouched
    {ALC, 16'h8060, 1'b1, 5'd6, 1'b0}   // R2 upper bits ignored
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // called at a falling edge; returns at the next falling edge with outputs sampled
  task automatic step(input logic [2:0] op, input logic [31:0] addr, input logic [4:0] way);
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = addr; cmd_way = way;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic alloc_chk(input string req, input logic [2:0] op, input logic [31:0] addr,
                           input logic [4:0] ew, input logic el);
    step(op, addr, 5'd0);
    chk({req, " valid"}, 32'(rsp_valid), 32'd1);
    chk({req, " way"},   32'(rsp_way),   32'(ew));
    chk({req, " lock"},  32'(rsp_lock_ok), 32'(el));
  endtask

  task automatic stat_chk(input string req, input logic [4:0] s,
                          input logic [31:0] ev, input logic [31:0] el);
    stat_set = s;
    @(negedge clk);
    chk({req, " stat_valid"},  stat_valid,  ev);
    chk({req, " stat_locked"}, stat_locked, el);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    rst = 1'b1; cmd_valid = 1'b0; cmd_op = '0; cmd_addr = '0; cmd_way = '0; stat_set = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1 cache_en", 32'(cache_en), 32'd0);
    stat_chk("R1", 5'd3, 32'h0, 32'h0);

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][25:23], 32'(VEC[i][22:7]), 5'd0);
      chk($sformatf("R12 vec%0d valid", i), 32'(rsp_valid), 32'(VEC[i][6]));
      if (VEC[i][6]) begin
        chk($sformatf("R3 vec%0d way", i),  32'(rsp_way),     32'(VEC[i][5:1]));
        chk($sformatf("R5 vec%0d lock", i), 32'(rsp_lock_ok), 32'(VEC[i][0]));
      end
    end
    stat_chk("R10 set3", 5'd3, 32'h0000_007F, 32'h0);

    // R4 full sweep and wrap in set 7
    for (int i = 0; i < 32; i++) alloc_chk("R4 sweep", ALC, 32'h0E0, 5'(i), 1'b0);
    alloc_chk("R4 wrap to 0", ALC, 32'h0E0, 5'd0, 1'b0);

    // R5 fill lock region of set 9
    for (int i = 0; i < 28; i++) alloc_chk("R5 lock fill", LCK, 32'h120, 5'(i), 1'b1);
    alloc_chk("R6 after locks", ALC, 32'h120, 5'd28, 1'b0);
    alloc_chk("R4", ALC, 32'h120, 5'd29, 1'b0);
    alloc_chk("R4", ALC, 32'h120, 5'd30, 1'b0);
    alloc_chk("R4", ALC, 32'h120, 5'd31, 1'b0);
    alloc_chk("R4 wrap to lowest unlocked", ALC, 32'h120, 5'd28, 1'b0);
    alloc_chk("R7 refused lock", LCK, 32'h120, 5'd31, 1'b0);
    alloc_chk("R7 pointer held", ALC, 32'h120, 5'd31, 1'b0);
    alloc_chk("R7 then wrap", ALC, 32'h120, 5'd28, 1'b0);
    stat_chk("R13 set9", 5'd9, 32'hFFFF_FFFF, 32'h0FFF_FFFF);

    step(IVA, 32'h0, 5'd0);
    chk("R8 no rsp", 32'(rsp_valid), 32'd0);
    stat_chk("R8 set9", 5'd9, 32'h0FFF_FFFF, 32'h0FFF_FFFF);
    stat_chk("R8 set7", 5'd7, 32'h0, 32'h0);
    stat_chk("R8 set3", 5'd3, 32'h0, 32'h0);

    alloc_chk("R12 after invalidate", ALC, 32'h120, 5'd29, 1'b0);
    stat_chk("R13 set9 refill", 5'd9, 32'h2FFF_FFFF, 32'h0FFF_FFFF);
    step(IVL, 32'h120, 5'd29);
    stat_chk("R9 line cleared", 5'd9, 32'h0FFF_FFFF, 32'h0FFF_FFFF);

    step(UNL, 32'h0, 5'd0);
    stat_chk("R10 unlocked", 5'd9, 32'h0FFF_FFFF, 32'h0);
    alloc_chk("R10", ALC, 32'h120, 5'd30, 1'b0);
    alloc_chk("R10", ALC, 32'h120, 5'd31, 1'b0);
    alloc_chk("R10 wrap to 0", ALC, 32'h120, 5'd0, 1'b0);

    // R12 back-to-back lock then alloc sees new pointer
    alloc_chk("R12 lock", LCK, 32'h140, 5'd0, 1'b1);
    alloc_chk("R12 next sees ptr", ALC, 32'h140, 5'd1, 1'b0);

    // R1 reset mid-run
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    chk("R1 en after reset", 32'(cache_en), 32'd0);
    stat_chk("R1 set9 cleared", 5'd9, 32'h0, 32'h0);
    step(ALC, 32'h120, 5'd0);
    chk("R1 disabled no rsp", 32'(rsp_valid), 32'd0);
    step(CTL, 32'h1000, 5'd0);
    chk("R11 en set", 32'(cache_en), 32'd1);
    alloc_chk("R1 pointer at 0", ALC, 32'h120, 5'd0, 1'b0);

    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

endmodule